// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block runs the acknowledge side of an eight-input priority interrupt controller that can be chained through a three-wire cascade bus. Priority resolution happens elsewhere. The block receives the winning input number and a pending flag, and from these it raises the interrupt line. It then counts the acknowledge strobes from the processor and decides, for each strobe, whether this device drives the data bus, an attached subordinate device drives it, or nobody does.

The device plays one of two roles. In the controller role it owns the cascade bus and names the subordinate that must answer. In the subordinate role it listens on that bus and answers only when it hears its own identity. Two processor protocols are supported:

- **Two-strobe vector mode:** the first strobe is silent and the vector byte follows on the second.
- **Three-byte call mode:** an opcode byte comes first, then the two bytes of a handler address.

The data output enable is asserted only for the strobe whose byte this device supplies. It can therefore also serve as the enable for an external bus transceiver.

Top module: `iack_seq_top`

## Requirements
- R1: The role is controller when `cfg_buffered`=0 and `sp_pin`=1, or when `cfg_buffered`=1 and `cfg_ms_bit`=1. Otherwise the role is subordinate. When `cfg_buffered`=1, `sp_pin` is ignored.
- R2: `int_out` equals `req_pending` while no acknowledge sequence is in progress. It is 0 while `ack_strobe` is high and between the strobes of a sequence.
- R3: In two-strobe mode (`cfg_mode86`=1), no device drives data during the first strobe.
- R4: In two-strobe mode, a controller whose selected input has no subordinate drives the byte `{cfg_vec_base[7:3], irq[2:0]}` during the second strobe.
- R5: A controller whose selected input has its bit set in `cfg_slave_word` drives the input number on `cas_out` with `cas_oe`=1. This starts at the first strobe and lasts until the sequence ends. Such a controller never drives data in two-strobe mode.
- R6: A subordinate drives data only when `cas_in` equals `cfg_slave_word[2:0]`.
- R7: In call mode (`cfg_mode86`=0), the controller always drives 0xCD on the first strobe, whether or not the input is cascaded. A subordinate never drives the first strobe.
- R8: In call mode, strobes two and three carry the low byte and then the high byte of the address `{cfg_call_base[15:6], irq[2:0], 3'b000}`. The owner of these bytes is the addressed subordinate, or the controller when the input has no subordinate.
- R9: After the falling edge of the last strobe (the second strobe in two-strobe mode, the third in call mode), the sequence returns to idle. At that point `cas_oe` drops and `int_out` follows `req_pending` again.
- R10: Synchronous reset returns the sequence to idle from any point, with `data_oe`=0 and `cas_oe`=0.
- R11: `data_oe` is 1 only while `ack_strobe` is high.
- R12: The input number is captured at the first strobe. Later changes of `req_num` within the sequence have no effect on the bytes or on `cas_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pending | input | 1 | A resolved request is waiting |
| req_num | input | 3 | Winning input number |
| ack_strobe | input | 1 | Acknowledge strobe, active high |
| cas_in | input | 3 | Cascade bus as seen at the pins |
| cfg_vec_base | input | 8 | Vector base; bits 7-3 are used |
| cfg_call_base | input | 16 | Handler address base for call mode; bits 15-6 are used |
| cfg_slave_word | input | 8 | Controller: per-input subordinate map. Subordinate: bits 2-0 hold its identity |
| sp_pin | input | 1 | Role pin, used when unbuffered |
| cfg_buffered | input | 1 | Buffered mode |
| cfg_ms_bit | input | 1 | Role bit, used when buffered |
| cfg_mode86 | input | 1 | 1 selects two-strobe vector mode; 0 selects three-byte call mode |
| int_out | output | 1 | Interrupt request to the processor or to the controller |
| data_out | output | 8 | Byte for the current strobe |
| data_oe | output | 1 | Data drive enable and buffer enable |
| cas_out | output | 3 | Cascade identity driven by the controller |
| cas_oe | output | 3 | Cascade drive enable, one bit per line |

## Verification
The main function is exercised through a table that crosses role with protocol. The rows cover an uncascaded controller, a cascaded controller, a subordinate that hears its own identity, and a subordinate that hears a different identity, in both protocols. Each row checks, strobe by strobe, which device owns the data bus. Further rows reach each role through the buffered path while `sp_pin` holds the opposite value, which separates the two ways the role can be chosen. Directed tests then change `req_num` in the middle of a sequence, assert reset between strobes, and check that `int_out` and `cas_oe` recover after the last strobe.

// File: rtl/iack_pkg.sv
package iack_pkg;
    localparam int IRQ_W   = 3;
    localparam int N_IRQ   = 1 << IRQ_W;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2 * DATA_W;
    localparam logic [DATA_W-1:0] CALL_OPCODE = 8'hCD;

    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_THIRD  = 2'd2
    } phase_e;

    typedef struct packed {
        logic              own;
        logic [DATA_W-1:0] value;
    } byte_slot_t;

    function automatic logic role_is_ctrl(input logic buffered, input logic ms_bit,
                                          input logic sp);
        return buffered ? ms_bit : sp;
    endfunction

    function automatic logic [DATA_W-1:0] vector_byte(input logic [DATA_W-1:0] base,
                                                      input logic [IRQ_W-1:0] irq);
        return {base[DATA_W-1:IRQ_W], irq};
    endfunction

    function automatic logic [ADDR_W-1:0] handler_addr(input logic [ADDR_W-1:0] base,
                                                       input logic [IRQ_W-1:0] irq);
        return {base[ADDR_W-1:2*IRQ_W], irq, {IRQ_W{1'b0}}};
    endfunction
endpackage

// File: rtl/iack_phase_ctr.sv
module iack_phase_ctr
    import iack_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ack_strobe,
    input  logic   mode86,
    output phase_e phase,
    output logic   ack_q,
    output logic   in_seq
);
    phase_e last_ph;
    logic   fall;

    assign last_ph = mode86 ? PH_SECOND : PH_THIRD;
    assign fall    = ack_q && !ack_strobe;
    assign in_seq  = (phase != PH_FIRST) || ack_strobe || ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FIRST;
            ack_q <= 1'b0;
        end else begin
            ack_q <= ack_strobe;
            if (fall) begin
                if (phase == last_ph || phase == PH_THIRD)
                    phase <= PH_FIRST;
                else
                    phase <= phase_e'(phase + 2'd1);
            end
        end
    end
endmodule

// File: rtl/iack_irq_latch.sv
module iack_irq_latch
    import iack_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic             ack_q,
    input  logic [IRQ_W-1:0] req_num,
    output logic [IRQ_W-1:0] sel_irq
);
    logic [IRQ_W-1:0] irq_q;
    logic             tracking;

    assign tracking = (phase == PH_FIRST) && !ack_q;
    assign sel_irq  = tracking ? req_num : irq_q;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= '0;
        else if (tracking)
            irq_q <= req_num;
    end
endmodule

// File: rtl/iack_byte_sel.sv
module iack_byte_sel
    import iack_pkg::*;
(
    input  logic              is_ctrl,
    input  logic              mode86,
    input  phase_e            phase,
    input  logic [IRQ_W-1:0]  sel_irq,
    input  logic [N_IRQ-1:0]  slave_word,
    input  logic [IRQ_W-1:0]  cas_in,
    input  logic [DATA_W-1:0] vec_base,
    input  logic [ADDR_W-1:0] call_base,
    output logic              cascaded,
    output byte_slot_t        slot
);
    logic              id_match;
    logic              tail_owner;
    logic [ADDR_W-1:0] addr;

    assign cascaded   = is_ctrl && slave_word[sel_irq];
    assign id_match   = (cas_in == slave_word[IRQ_W-1:0]);
    assign tail_owner = is_ctrl ? !cascaded : id_match;
    assign addr       = handler_addr(call_base, sel_irq);

    always_comb begin
        slot = '{own: 1'b0, value: '0};
        if (mode86) begin
            if (phase == PH_SECOND) begin
                slot.own   = tail_owner;
                slot.value = vector_byte(vec_base, sel_irq);
            end
        end else begin
            unique case (phase)
                PH_FIRST: begin
                    slot.own   = is_ctrl;
                    slot.value = CALL_OPCODE;
                end
                PH_SECOND: begin
                    slot.own   = tail_owner;
                    slot.value = addr[DATA_W-1:0];
                end
                default: begin
                    slot.own   = tail_owner;
                    slot.value = addr[ADDR_W-1:DATA_W];
                end
            endcase
        end
    end
endmodule

// File: rtl/iack_seq_top.sv
module iack_seq_top
    import iack_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_pending,
    input  logic [2:0]  req_num,
    input  logic        ack_strobe,
    input  logic [2:0]  cas_in,
    input  logic [7:0]  cfg_vec_base,
    input  logic [15:0] cfg_call_base,
    input  logic [7:0]  cfg_slave_word,
    input  logic        sp_pin,
    input  logic        cfg_buffered,
    input  logic        cfg_ms_bit,
    input  logic        cfg_mode86,
    output logic        int_out,
    output logic [7:0]  data_out,
    output logic        data_oe,
    output logic [2:0]  cas_out,
    output logic [2:0]  cas_oe
);
    phase_e           phase;
    logic             ack_q;
    logic             in_seq;
    logic [IRQ_W-1:0] sel_irq;
    logic             is_ctrl;
    logic             cascaded;
    byte_slot_t       slot;

    assign is_ctrl = role_is_ctrl(cfg_buffered, cfg_ms_bit, sp_pin);

    iack_phase_ctr u_phase (
        .clk        (clk),
        .rst        (rst),
        .ack_strobe (ack_strobe),
        .mode86     (cfg_mode86),
        .phase      (phase),
        .ack_q      (ack_q),
        .in_seq     (in_seq)
    );

    iack_irq_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .ack_q   (ack_q),
        .req_num (req_num),
        .sel_irq (sel_irq)
    );

    iack_byte_sel u_sel (
        .is_ctrl    (is_ctrl),
        .mode86     (cfg_mode86),
        .phase      (phase),
        .sel_irq    (sel_irq),
        .slave_word (cfg_slave_word),
        .cas_in     (cas_in),
        .vec_base   (cfg_vec_base),
        .call_base  (cfg_call_base),
        .cascaded   (cascaded),
        .slot       (slot)
    );

    assign int_out  = req_pending && !in_seq;
    assign data_oe  = ack_strobe && slot.own;
    assign data_out = slot.value;
    assign cas_out  = sel_irq;

    for (genvar g = 0; g < IRQ_W; g++) begin : g_cas_en
        assign cas_oe[g] = cascaded && in_seq;
    end
endmodule

// File: rtl/iack_seq_chk.sv
module iack_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_pending,
    input logic        ack_strobe,
    input logic [2:0]  cas_in,
    input logic [7:0]  cfg_slave_word,
    input logic        sp_pin,
    input logic        cfg_buffered,
    input logic        cfg_ms_bit,
    input logic        cfg_mode86,
    input logic        int_out,
    input logic        data_oe,
    input logic [2:0]  cas_oe
);
    logic ctrl_role;
    assign ctrl_role = cfg_buffered ? cfg_ms_bit : sp_pin;

    assert_oe_in_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> ack_strobe);

    assert_oe_drop_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_strobe) |-> !data_oe);

    assert_cas_ctrl_only_R5: assert property (@(posedge clk) disable iff (rst)
        (cas_oe != 3'b000) |-> ctrl_role);

    assert_cas_no_data86_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode86 && cas_oe != 3'b000) |-> !data_oe);

    assert_sub_id_match_R6: assert property (@(posedge clk) disable iff (rst)
        (data_oe && !ctrl_role) |-> (cas_in == cfg_slave_word[2:0]));

    assert_int_idle_R2: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (req_pending && !ack_strobe));
endmodule

bind iack_seq_top iack_seq_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .req_pending    (req_pending),
    .ack_strobe     (ack_strobe),
    .cas_in         (cas_in),
    .cfg_slave_word (cfg_slave_word),
    .sp_pin         (sp_pin),
    .cfg_buffered   (cfg_buffered),
    .cfg_ms_bit     (cfg_ms_bit),
    .cfg_mode86     (cfg_mode86),
    .int_out        (int_out),
    .data_oe        (data_oe),
    .cas_oe         (cas_oe)
);

// File: tb/iack_seq_top_tb_top.sv
`timescale 1ns/1ps
module iack_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_pending = 1'b0;
    logic [2:0]  req_num = '0;
    logic        ack_strobe = 1'b0;
    logic [2:0]  cas_in = '0;
    logic [7:0]  cfg_vec_base = 8'h48;
    logic [15:0] cfg_call_base = 16'h1240;
    logic [7:0]  cfg_slave_word = '0;
    logic        sp_pin = 1'b1;
    logic        cfg_buffered = 1'b0;
    logic        cfg_ms_bit = 1'b0;
    logic        cfg_mode86 = 1'b1;
    logic        int_out;
    logic [7:0]  data_out;
    logic        data_oe;
    logic [2:0]  cas_out;
    logic [2:0]  cas_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    iack_seq_top dut_i (
        .clk(clk), .rst(rst), .req_pending(req_pending), .req_num(req_num),
        .ack_strobe(ack_strobe), .cas_in(cas_in), .cfg_vec_base(cfg_vec_base),
        .cfg_call_base(cfg_call_base), .cfg_slave_word(cfg_slave_word),
        .sp_pin(sp_pin), .cfg_buffered(cfg_buffered), .cfg_ms_bit(cfg_ms_bit),
        .cfg_mode86(cfg_mode86), .int_out(int_out), .data_out(data_out),
        .data_oe(data_oe), .cas_out(cas_out), .cas_oe(cas_oe)
    );

    typedef struct packed {
        logic       m86;
        logic       sp;
        logic       bufm;
        logic       ms;
        logic [7:0] sw;
        logic [2:0] irq;
        logic [2:0] cin;
        logic       ecas;
        logic [2:0] eoe;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b1,1'b0,1'b0, 8'h00, 3'd3, 3'd0, 1'b0, 3'b010, 8'h00, 8'h4B, 8'h00},
        '{1'b1,1'b1,1'b0,1'b0, 8'h04, 3'd2, 3'd0, 1'b1, 3'b000, 8'h00, 8'h00, 8'h00},
        '{1'b1,1'b0,1'b0,1'b0, 8'h05, 3'd6, 3'd5, 1'b0, 3'b010, 8'h00, 8'h4E, 8'h00},
        '{1'b1,1'b0,1'b0,1'b0, 8'h05, 3'd6, 3'd3, 1'b0, 3'b000, 8'h00, 8'h00, 8'h00},
        '{1'b0,1'b1,1'b0,1'b0, 8'h00, 3'd1, 3'd0, 1'b0, 3'b111, 8'hCD, 8'h48, 8'h12},
        '{1'b0,1'b1,1'b0,1'b0, 8'h80, 3'd7, 3'd0, 1'b1, 3'b001, 8'hCD, 8'h00, 8'h00},
        '{1'b0,1'b0,1'b0,1'b0, 8'h02, 3'd4, 3'd2, 1'b0, 3'b110, 8'h00, 8'h60, 8'h12},
        '{1'b1,1'b0,1'b1,1'b1, 8'h00, 3'd0, 3'd0, 1'b0, 3'b010, 8'h00, 8'h48, 8'h00},
        '{1'b1,1'b1,1'b1,1'b0, 8'h01, 3'd5, 3'd1, 1'b0, 3'b010, 8'h00, 8'h4D, 8'h00},
        '{1'b0,1'b0,1'b0,1'b0, 8'h02, 3'd4, 3'd6, 1'b0, 3'b000, 8'h00, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic       s_oe;
    logic [7:0] s_d;
    logic [2:0] s_coe;
    logic [2:0] s_c;
    logic       s_int;

    task automatic strobe();
        @(negedge clk) ack_strobe = 1'b1;
        @(posedge clk); #1;
        s_oe = data_oe; s_d = data_out; s_coe = cas_oe; s_c = cas_out; s_int = int_out;
        @(negedge clk) ack_strobe = 1'b0;
        @(posedge clk); @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!done) begin
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: idle after reset
        check("R10 data_oe", 16'(data_oe), 16'd0);
        check("R10 cas_oe", 16'(cas_oe), 16'd0);
        req_pending = 1'b1;
        #1;
        check("R2 int idle", 16'(int_out), 16'd1);

        for (int v = 0; v < NV; v++) begin
            vec_t t = TBL[v];
            int np = t.m86 ? 2 : 3;
            logic [7:0] eb [3];
            eb[0] = t.b0; eb[1] = t.b1; eb[2] = t.b2;
            @(negedge clk);
            cfg_mode86 = t.m86; sp_pin = t.sp; cfg_buffered = t.bufm; cfg_ms_bit = t.ms;
            cfg_slave_word = t.sw; req_num = t.irq; cas_in = t.cin; req_pending = 1'b1;
            @(posedge clk); #1;
            for (int p = 0; p < np; p++) begin
                strobe();
                // R3 R4 R6 R7 R8 R1: ownership per strobe
                check($sformatf("R1/R3/R4/R6/R7/R8 v%0d p%0d oe", v, p), 16'(s_oe), 16'(t.eoe[p]));
                if (t.eoe[p])
                    check($sformatf("R4/R7/R8 v%0d p%0d byte", v, p), 16'(s_d), 16'(eb[p]));
                check($sformatf("R5 v%0d p%0d cas_oe", v, p), 16'(s_coe), t.ecas ? 16'h7 : 16'h0);
                if (t.ecas)
                    check($sformatf("R5 v%0d p%0d cas", v, p), 16'(s_c), 16'(t.irq));
                check($sformatf("R2 v%0d p%0d int in strobe", v, p), 16'(s_int), 16'd0);
                if (p < np - 1) begin
                    check($sformatf("R5 v%0d gap cas_oe", v), 16'(cas_oe), t.ecas ? 16'h7 : 16'h0);
                    check($sformatf("R2 v%0d gap int", v), 16'(int_out), 16'd0);
                end
            end
            // R9: back to idle
            check($sformatf("R9 v%0d cas released", v), 16'(cas_oe), 16'd0);
            check($sformatf("R9 v%0d int again", v), 16'(int_out), 16'd1);
        end

        // R12: req_num change after first strobe is ignored
        @(negedge clk);
        cfg_mode86 = 1'b1; sp_pin = 1'b1; cfg_buffered = 1'b0; cfg_slave_word = 8'h00;
        req_num = 3'd3;
        @(posedge clk); #1;
        strobe();
        req_num = 3'd6;
        strobe();
        check("R12 latched vector", 16'(s_d), 16'h4B);

        // R12 cascaded: cas stays on captured input
        @(negedge clk); cfg_slave_word = 8'h02; req_num = 3'd1;
        @(posedge clk); #1;
        strobe();
        req_num = 3'd4;
        #1;
        check("R12 cas held", 16'(cas_out), 16'd1);
        check("R12 cas_oe held", 16'(cas_oe), 16'h7);
        strobe();
        check("R9 cascaded end", 16'(cas_oe), 16'd0);

        // R10: reset mid-sequence
        @(negedge clk); cfg_mode86 = 1'b0; cfg_slave_word = 8'h02; req_num = 3'd1;
        @(posedge clk); #1;
        strobe();
        check("R10 pre-reset cas_oe", 16'(cas_oe), 16'h7);
        do_reset();
        check("R10 mid reset cas_oe", 16'(cas_oe), 16'd0);
        check("R10 mid reset int", 16'(int_out), 16'd1);
        cfg_slave_word = 8'h00; req_num = 3'd2;
        strobe();
        check("R10 restart opcode", 16'(s_d), 16'hCD);
        check("R10 restart oe", 16'(s_oe), 16'd1);
        strobe();
        check("R8 restart low byte", 16'(s_d), 16'h50);
        strobe();
        check("R8 restart high byte", 16'(s_d), 16'h12);

        // R2: no pending, no interrupt
        req_pending = 1'b0;
        #1;
        check("R2 no pending", 16'(int_out), 16'd0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule